// File: doc/BRIEF.md
# Configurable Multi-Port I/O Controller

This block sits between a microcontroller's register bus and a group of four general-purpose pin ports. Three ports are eight pins wide and the fourth has three pins. Software sets each pin as an input or an output, sets its open-drain drive flag, and writes its output data. On the first two ports, software can also choose, pin by pin, to drive a bit of the external address bus instead of the written data. All pins of the four ports leave the block as flat vectors that a pad ring consumes.

The register bus is synchronous. A write takes effect on the clock edge where the write strobe is sampled. Read data appears on `rdata` in the cycle after the read strobe. Pin inputs pass through a two-stage synchronizer before software can see them.

Top module: `mpio_ctrl`

## Requirements
- R1: After reset, every stored register bit and data-out latch is 0. `pin_oe` and `pin_drv` are all zero, and every register location reads back 0 while the pins are held low.
- R2: Address bits [1:0] select the port (0 to 3 for the first to the fourth port). Bits [3:2] select the register: 0 is data, 1 is direction, 2 is drive select, 3 is output-source select. An address with bit 4 set maps to nothing: a write there has no effect and a read returns 0. Register bit n controls pin n of its port. In the flat pin vectors, port 0 occupies bits [7:0], port 1 bits [15:8], port 2 bits [23:16] and port 3 bits [26:24].
- R3: A write changes the register in the clock edge where `wr` is sampled. `rdata` carries the addressed value in the cycle after `rd` is sampled high, and is 0 in the cycle after a cycle without `rd`.
- R4: A pin's direction bit set to 1 makes it an output, and set to 0 makes it an input. An input never has `pin_oe` asserted.
- R5: On ports 0 and 1, an output-source bit of 1 makes `pin_out` follow the matching `mcu_addr` bit: `mcu_addr[7:0]` for port 0 and `mcu_addr[15:8]` for port 1. An output-source bit of 0 makes the pin take the data-out latch bit.
- R6: Ports 2 and 3 have no output-source register. Reads of that location return 0, writes to it are ignored, and their pins always take the latch value.
- R7: Each drive-select bit appears directly on `pin_drv`. When it is set on an output pin whose output value is 1, `pin_oe` is deasserted, so the pin behaves as open drain.
- R8: Port 3 stores only bits [2:0] of each register. Bits [7:3] read as 0 and ignore writes.
- R9: A data read returns, for each pin, the latch bit if the pin is an output and the synchronized input if it is an input. A change on `pin_in` shows in a read whose `rd` is sampled on the third rising edge after the change, and not in a read sampled on the first or second.
- R10: A read and a write to the same location in one cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Read data, one cycle after `rd` |
| mcu_addr | input | 16 | Address bus offered to ports 0 and 1 |
| pin_in | input | 27 | Pin input levels |
| pin_out | output | 27 | Pin output values |
| pin_oe | output | 27 | Pin output enables |
| pin_drv | output | 27 | Per-pin drive-select flags |

## Verification
The properties assume that `wr` and `rd` are clean single-cycle strobes, sampled on rising edges, with `addr` and `wdata` stable around the edge. They also assume that reset is applied before the first bus cycle. The bench drives every input on the falling edge, one bus operation per cycle. Addresses span the whole 5-bit space, including the unmapped half. Apart from the directed synchronizer-latency test, the bench changes `pin_in` only when at least three idle cycles follow before the next data read.

// File: rtl/mpio_pkg.sv
package mpio_pkg;
    localparam int DATA_W       = 8;
    localparam int ADDR_W       = 5;
    localparam int N_PORTS      = 4;
    localparam int LAST_PORT_W  = 3;
    localparam int N_MODE_PORTS = 2;
    localparam int MADDR_W      = N_MODE_PORTS * DATA_W;
    localparam int PSEL_W       = $clog2(N_PORTS);
    localparam int N_PINS       = (N_PORTS - 1) * DATA_W + LAST_PORT_W;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_DRV  = 2'd2,
        REG_SRC  = 2'd3
    } reg_kind_e;

    function automatic int port_w(input int p);
        return (p == N_PORTS - 1) ? LAST_PORT_W : DATA_W;
    endfunction

    function automatic int port_lo(input int p);
        return p * DATA_W;
    endfunction
endpackage

// File: rtl/mpio_sync.sv
module mpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/mpio_port.sv
module mpio_port
    import mpio_pkg::*;
#(
    parameter int W        = 8,
    parameter bit HAS_MODE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lat,
    input  logic              wr_dir,
    input  logic              wr_drv,
    input  logic              wr_src,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      addr_src,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      pin_drv,
    output logic [DATA_W-1:0] rd_dat,
    output logic [DATA_W-1:0] rd_dir,
    output logic [DATA_W-1:0] rd_drv,
    output logic [DATA_W-1:0] rd_src
);
    typedef struct packed {
        logic [W-1:0] lat;
        logic [W-1:0] dir;
        logic [W-1:0] drv;
        logic [W-1:0] src;
    } port_t;

    port_t        st_d, st_q;
    logic [W-1:0] pin_sync;
    logic [W-1:0] out_val;

    mpio_sync #(.W(W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    always_comb begin
        st_d = st_q;
        if (wr_lat) st_d.lat = wdata;
        if (wr_dir) st_d.dir = wdata;
        if (wr_drv) st_d.drv = wdata;
        if (HAS_MODE && wr_src) st_d.src = wdata;
        if (!HAS_MODE) st_d.src = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // output value: address bit where selected, latch otherwise
    assign out_val = (st_q.src & addr_src) | (~st_q.src & st_q.lat);
    assign pin_out = out_val;
    assign pin_drv = st_q.drv;
    // open drain: a flagged pin releases instead of driving high
    assign pin_oe  = st_q.dir & ~(st_q.drv & out_val);

    always_comb begin
        rd_dat = '0;
        rd_dir = '0;
        rd_drv = '0;
        rd_src = '0;
        rd_dat[W-1:0] = (st_q.dir & st_q.lat) | (~st_q.dir & pin_sync);
        rd_dir[W-1:0] = st_q.dir;
        rd_drv[W-1:0] = st_q.drv;
        rd_src[W-1:0] = st_q.src;
    end
endmodule

// File: rtl/mpio_ctrl.sv
module mpio_ctrl
    import mpio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               wr,
    input  logic               rd,
    output logic [DATA_W-1:0]  rdata,
    input  logic [MADDR_W-1:0] mcu_addr,
    input  logic [N_PINS-1:0]  pin_in,
    output logic [N_PINS-1:0]  pin_out,
    output logic [N_PINS-1:0]  pin_oe,
    output logic [N_PINS-1:0]  pin_drv
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t              st_d, st_q;
    logic [PSEL_W-1:0] port_sel;
    reg_kind_e         kind;
    logic              hit;
    logic [DATA_W-1:0] rd_dat [N_PORTS];
    logic [DATA_W-1:0] rd_dir [N_PORTS];
    logic [DATA_W-1:0] rd_drv [N_PORTS];
    logic [DATA_W-1:0] rd_src [N_PORTS];

    assign port_sel = addr[PSEL_W-1:0];
    assign kind     = reg_kind_e'(addr[PSEL_W+1:PSEL_W]);
    assign hit      = (addr[ADDR_W-1:PSEL_W+2] == '0);

    for (genvar i = 0; i < N_PORTS; i++) begin : g_port
        localparam int W  = port_w(i);
        localparam int LO = port_lo(i);
        logic [W-1:0] asrc;
        logic         sel;

        if (i < N_MODE_PORTS) begin : g_src
            assign asrc = mcu_addr[i*DATA_W +: W];
        end else begin : g_nosrc
            assign asrc = '0;
        end

        assign sel = wr && hit && (port_sel == PSEL_W'(i));

        mpio_port #(.W(W), .HAS_MODE(i < N_MODE_PORTS)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lat   (sel && kind == REG_DATA),
            .wr_dir   (sel && kind == REG_DIR),
            .wr_drv   (sel && kind == REG_DRV),
            .wr_src   (sel && kind == REG_SRC),
            .wdata    (wdata[W-1:0]),
            .addr_src (asrc),
            .pin_in   (pin_in[LO +: W]),
            .pin_out  (pin_out[LO +: W]),
            .pin_oe   (pin_oe[LO +: W]),
            .pin_drv  (pin_drv[LO +: W]),
            .rd_dat   (rd_dat[i]),
            .rd_dir   (rd_dir[i]),
            .rd_drv   (rd_drv[i]),
            .rd_src   (rd_src[i])
        );
    end

    always_comb begin
        st_d.rdata = '0;
        if (rd && hit) begin
            unique case (kind)
                REG_DATA: st_d.rdata = rd_dat[port_sel];
                REG_DIR:  st_d.rdata = rd_dir[port_sel];
                REG_DRV:  st_d.rdata = rd_drv[port_sel];
                REG_SRC:  st_d.rdata = rd_src[port_sel];
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
endmodule

// File: rtl/mpio_ctrl_chk.sv
module mpio_ctrl_chk
    import mpio_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr,
    input logic              rd,
    input logic [DATA_W-1:0] rdata,
    input logic [N_PINS-1:0] pin_out,
    input logic [N_PINS-1:0] pin_oe,
    input logic [N_PINS-1:0] pin_drv
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_drv == '0 && rdata == '0));

    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr[ADDR_W-1]) |=> (rdata == '0));

    p_rd_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (rdata == '0));

    p_drv_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(pin_drv));

    p_open_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & pin_drv & pin_out) == '0);

    p_last_port_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !addr[ADDR_W-1] && addr[PSEL_W-1:0] == PSEL_W'(N_PORTS - 1))
        |=> (rdata[DATA_W-1:LAST_PORT_W] == '0));
endmodule

bind mpio_ctrl mpio_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr      (wr),
    .rd      (rd),
    .rdata   (rdata),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .pin_drv (pin_drv)
);

// File: tb/mpio_ctrl_tb.sv
module mpio_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 27;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    addr = '0;
    logic [7:0]    wdata = '0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [7:0]    rdata;
    logic [15:0]   mcu_addr = '0;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe, pin_drv;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    logic [7:0]    m_lat [4], m_dir [4], m_drv [4], m_src [4];
    logic [NP-1:0] e_out, e_oe, e_drv;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
        .rdata(rdata), .mcu_addr(mcu_addr), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_drv(pin_drv)
    );

    function automatic logic [7:0] pmask(input int p);
        return (p == 3) ? 8'h07 : 8'hFF;
    endfunction

    // R2 R6 R8 model of a write
    function automatic void mdl_write(input logic [4:0] a, input logic [7:0] d);
        int p = int'(a[1:0]);
        if (a[4]) return;
        case (a[3:2])
            2'd0: m_lat[p] = d & pmask(p);
            2'd1: m_dir[p] = d & pmask(p);
            2'd2: m_drv[p] = d & pmask(p);
            default: if (p < 2) m_src[p] = d;
        endcase
    endfunction

    // R9 model of a read with settled pins
    function automatic logic [7:0] mdl_read(input logic [4:0] a);
        int p = int'(a[1:0]);
        logic [7:0] pv;
        if (a[4]) return 8'h00;
        pv = (p == 3) ? {5'b0, pin_in[26:24]} : pin_in[p*8 +: 8];
        case (a[3:2])
            2'd0: return ((m_dir[p] & m_lat[p]) | (~m_dir[p] & pv)) & pmask(p);
            2'd1: return m_dir[p];
            2'd2: return m_drv[p];
            default: return m_src[p];
        endcase
    endfunction

    // R4 R5 R7 expected pin vectors
    function automatic void mdl_pins();
        for (int p = 0; p < 4; p++) begin
            for (int b = 0; b < ((p == 3) ? 3 : 8); b++) begin
                logic ov;
                ov = (p < 2 && m_src[p][b]) ? mcu_addr[p*8+b] : m_lat[p][b];
                e_out[p*8+b] = ov;
                e_drv[p*8+b] = m_drv[p][b];
                e_oe[p*8+b]  = m_dir[p][b] & ~(m_drv[p][b] & ov);
            end
        end
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_pins(input string req);
        mdl_pins();
        chk({req, " pin_out"}, 32'(pin_out), 32'(e_out));
        chk({req, " pin_oe"},  32'(pin_oe),  32'(e_oe));
        chk({req, " pin_drv"}, 32'(pin_drv), 32'(e_drv));
    endtask

    task automatic bus(input logic w, input logic r, input logic [4:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = w; rd = r;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
    endtask

    task automatic do_write(input logic [4:0] a, input logic [7:0] d);
        bus(1'b1, 1'b0, a, d);
        mdl_write(a, d);
    endtask

    task automatic do_read(input logic [4:0] a, input string req);
        logic [7:0] e;
        e = mdl_read(a);
        bus(1'b0, 1'b1, a, 8'h00);
        chk(req, 32'(rdata), 32'(e));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        for (int p = 0; p < 4; p++) begin
            m_lat[p] = '0; m_dir[p] = '0; m_drv[p] = '0; m_src[p] = '0;
        end
        e_out = '0; e_oe = '0; e_drv = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk_pins("R1");
        for (int a = 0; a < 16; a++) do_read(5'(a), "R1 reset readback");

        // R2 unmapped write and read
        do_write(5'h14, 8'hFF);
        do_read(5'h14, "R2 unmapped read");
        do_read(5'h04, "R2 dir A unchanged");
        chk_pins("R2");

        // R5 R7 address source on port 0
        do_write(5'h04, 8'hFF);
        do_write(5'h00, 8'h0F);
        do_write(5'h0C, 8'hF0);
        mcu_addr = 16'h55AA;
        idle(1);
        chk_pins("R5");
        chk(("R5 A value"), 32'(pin_out[7:0]), 32'hAF);
        do_write(5'h08, 8'h3C);
        chk_pins("R7");
        do_read(5'h08, "R7 drv readback");

        // R6 no source register on port 2
        do_write(5'h0E, 8'hFF);
        do_read(5'h0E, "R6 src C reads zero");
        do_write(5'h06, 8'hFF);
        do_write(5'h02, 8'h00);
        chk_pins("R6");
        chk("R6 C follows latch", 32'(pin_out[23:16]), 32'h00);

        // R8 last port upper bits
        do_write(5'h07, 8'hFF);
        do_read(5'h07, "R8 dir D");
        chk("R8 dir D value", 32'(rdata), 32'h07);

        // R10 read and write same cycle
        begin
            logic [7:0] old;
            old = mdl_read(5'h09);
            bus(1'b1, 1'b1, 5'h09, 8'hA5);
            mdl_write(5'h09, 8'hA5);
            chk("R10 old value", 32'(rdata), 32'(old));
            do_read(5'h09, "R10 new value");
        end

        // R3 rdata zero after idle cycle
        idle(1);
        chk("R3 idle rdata", 32'(rdata), 32'h00);

        // R9 synchronizer latency on port 1 inputs
        do_write(5'h05, 8'h00);
        do_write(5'h0D, 8'h00);
        pin_in[15:8] = 8'h00;
        idle(3);
        do_read(5'h01, "R9 baseline");
        pin_in[15:8] = 8'hC3;
        bus(1'b0, 1'b1, 5'h01, 8'h00);
        chk("R9 first edge old", 32'(rdata), 32'h00);
        bus(1'b0, 1'b1, 5'h01, 8'h00);
        chk("R9 second edge old", 32'(rdata), 32'h00);
        bus(1'b0, 1'b1, 5'h01, 8'h00);
        chk("R9 third edge new", 32'(rdata), 32'hC3);

        // R4 R9 mixed directions
        do_write(5'h05, 8'h0F);
        do_write(5'h01, 8'hFF);
        do_read(5'h01, "R9 mixed read");

        // random traffic
        for (int it = 0; it < 600; it++) begin
            logic [4:0] a;
            pin_in   = NP'($urandom);
            mcu_addr = 16'($urandom);
            idle(3);
            a = 5'($urandom);
            do_write(a, 8'($urandom));
            chk_pins("R4 random");
            do_read(5'($urandom), "R2 random read");
            if (it % 4 == 0) do_read(a, "R3 readback");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule